// File: doc/BRIEF.md
# Dual-Processor Mailbox FIFO Pair

This block joins two processors that run on one clock through a pair of message queues, one per direction. Each processor owns a send queue that holds up to sixteen 32-bit words. The other processor reads those words in order through its receive port. Each side has three access points: a 16-bit control/status register, a send-data write strobe and a receive-data read strobe. Bus decoding is done outside the block.

The status bits are cross-coupled. A side's receive-empty and receive-full bits always show the state of the other side's send queue. Faulty accesses set a sticky error flag, which software clears by writing one to it. Two kinds of interrupt request go to each processor: send-empty and receive-not-empty. Both are one-cycle pulses. An interrupt can be raised by a queue event. It can also be raised by a control write that enables the interrupt while its condition already holds.

Top module: `ipc_mailbox_pair`

## Requirements
- R1: Each direction holds up to DEPTH (16) words of DATA_W (32) bits. Words are delivered in write order. The storage positions wrap after the last index.
- R2: Control bit 15 enables a side. While it is 0, that side's send write is ignored, and its receive read returns 0 and changes no state.
- R3: Status bits of the control register:
  - bit 0: own send queue empty
  - bit 1: own send queue full
  - bit 8: other side's send queue empty (receive-empty)
  - bit 9: other side's send queue full (receive-full)

  Bits 8 and 9 of one side always equal bits 0 and 1 of the other side.
- R4: A send write to a full queue drops the word and sets the error flag, bit 14. A receive read while the other side's queue is empty returns 0 and sets bit 14.
- R5: Writing 1 to bit 14 clears the error flag. Writing 0 leaves it unchanged.
- R6: Writing 1 to bit 3 empties the writer's own send queue. Both sides then show that queue as empty and not full. A send write in the same cycle is dropped without an error. Bit 3 always reads 0.
- R7: A word is accepted while the receiver's bit 10 (receive-interrupt enable) is set. The receiver's receive interrupt then pulses high for exactly the one cycle after the write edge.
- R8: A read can take the last word of a queue with no write to that queue in the same cycle. Both empty bits then become 1, and if the sender's bit 2 (send-interrupt enable) is set, the sender's send-empty interrupt pulses for one cycle.
- R9: A control write that sets bit 2 pulses the send-empty interrupt if the own queue is empty or is being cleared by the same write. A control write that sets bit 10 pulses the receive interrupt if the other side's queue is not empty.
- R10: After reset both queues are empty, all enables and error flags are 0, both registers read 16'h0101, and no interrupt is active.
- R11: A send write and a read of the same non-full, non-empty queue in one cycle are both carried out, and the word count stays the same.
- R12: Bits 2 and 10 read back as written. Bits 13 to 11 and 7 to 4 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ctl_we | input | 1 | Side A control register write strobe |
| a_ctl_wdata | input | 16 | Side A control write data |
| a_ctl_rdata | output | 16 | Side A control/status readback |
| a_tx_we | input | 1 | Side A send-data write strobe |
| a_tx_wdata | input | 32 | Side A send word |
| a_rx_re | input | 1 | Side A receive read strobe (pops in this cycle) |
| a_rx_rdata | output | 32 | Side A received word, valid while a_rx_re is high |
| a_irq_tx_empty | output | 1 | Side A send-empty interrupt pulse |
| a_irq_rx_avail | output | 1 | Side A receive-not-empty interrupt pulse |
| b_ctl_we | input | 1 | Side B control register write strobe |
| b_ctl_wdata | input | 16 | Side B control write data |
| b_ctl_rdata | output | 16 | Side B control/status readback |
| b_tx_we | input | 1 | Side B send-data write strobe |
| b_tx_wdata | input | 32 | Side B send word |
| b_rx_re | input | 1 | Side B receive read strobe (pops in this cycle) |
| b_rx_rdata | output | 32 | Side B received word, valid while b_rx_re is high |
| b_irq_tx_empty | output | 1 | Side B send-empty interrupt pulse |
| b_irq_rx_avail | output | 1 | Side B receive-not-empty interrupt pulse |

## Verification
On every cycle, the assertions check these properties:
- the word count stays within bounds
- each side's receive bits mirror the other side's send bits
- a full queue refuses a write
- the error flag stays set until a write of one clears it
- a disabled side reads zero
- a clear empties the queue
- a draining read shows up as receive-empty at the reader

Only the bench's scenarios can show the rest:
- the order of the delivered data across pointer wrap-around
- whether an interrupt fires on exactly the right event, and only for one cycle
- the immediate interrupts on control writes
- the handling of a write and a read in the same cycle

// File: rtl/ipc_mailbox_pair.sv
module ipc_mailbox_pair #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_ctl_we,
  input  logic [15:0]       a_ctl_wdata,
  output logic [15:0]       a_ctl_rdata,
  input  logic              a_tx_we,
  input  logic [DATA_W-1:0] a_tx_wdata,
  input  logic              a_rx_re,
  output logic [DATA_W-1:0] a_rx_rdata,
  output logic              a_irq_tx_empty,
  output logic              a_irq_rx_avail,
  input  logic              b_ctl_we,
  input  logic [15:0]       b_ctl_wdata,
  output logic [15:0]       b_ctl_rdata,
  input  logic              b_tx_we,
  input  logic [DATA_W-1:0] b_tx_wdata,
  input  logic              b_rx_re,
  output logic [DATA_W-1:0] b_rx_rdata,
  output logic              b_irq_tx_empty,
  output logic              b_irq_rx_avail
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int B_EN = 15, B_ERR = 14, B_RIE = 10, B_CLR = 3, B_TIE = 2;

  logic [1:0]        ctl_we, tx_we, rx_re;
  logic [15:0]       ctl_wd [2];
  logic [15:0]       ctl_rd [2];
  logic [DATA_W-1:0] tx_wd [2];
  logic [DATA_W-1:0] rx_rd [2];

  logic [DATA_W-1:0] mem [2][DEPTH];
  logic [PTR_W-1:0]  wp [2];
  logic [PTR_W-1:0]  rp [2];
  logic [CNT_W-1:0]  cnt [2];
  logic [1:0]        en, err, tie, rie, irq_tx, irq_rx;

  logic [1:0] full, empty, clr, push, push_err, pop, rd_err, irq_tx_n, irq_rx_n;

  assign ctl_we = {b_ctl_we, a_ctl_we};
  assign tx_we  = {b_tx_we, a_tx_we};
  assign rx_re  = {b_rx_re, a_rx_re};
  assign ctl_wd[0] = a_ctl_wdata;
  assign ctl_wd[1] = b_ctl_wdata;
  assign tx_wd[0]  = a_tx_wdata;
  assign tx_wd[1]  = b_tx_wdata;

  assign a_ctl_rdata    = ctl_rd[0];
  assign b_ctl_rdata    = ctl_rd[1];
  assign a_rx_rdata     = rx_rd[0];
  assign b_rx_rdata     = rx_rd[1];
  assign a_irq_tx_empty = irq_tx[0];
  assign b_irq_tx_empty = irq_tx[1];
  assign a_irq_rx_avail = irq_rx[0];
  assign b_irq_rx_avail = irq_rx[1];

  logic unused_wbits;
  assign unused_wbits = ^{ctl_wd[0][13:11], ctl_wd[0][9:4], ctl_wd[0][1:0],
                          ctl_wd[1][13:11], ctl_wd[1][9:4], ctl_wd[1][1:0]};

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      full[s]     = (cnt[s] == CNT_W'(DEPTH));
      empty[s]    = (cnt[s] == '0);
      clr[s]      = ctl_we[s] & ctl_wd[s][B_CLR];
      push[s]     = tx_we[s] & en[s] & ~full[s] & ~clr[s];
      push_err[s] = tx_we[s] & en[s] & full[s] & ~clr[s];
    end
    for (int s = 0; s < 2; s++) begin
      pop[s]    = rx_re[1-s] & en[1-s] & ~empty[s];
      rd_err[s] = rx_re[s] & en[s] & empty[1-s];
      rx_rd[s]  = (rx_re[s] & en[s] & ~empty[1-s]) ? mem[1-s][rp[1-s]] : '0;
      ctl_rd[s] = {en[s], err[s], 3'b000, rie[s], full[1-s], empty[1-s],
                   5'b00000, tie[s], full[s], empty[s]};
      irq_rx_n[s] = (push[1-s] & rie[s])
                  | (ctl_we[s] & ctl_wd[s][B_RIE] & ~empty[1-s]);
      irq_tx_n[s] = (pop[s] & ~push[s] & ~clr[s] & (cnt[s] == CNT_W'(1)) & tie[s])
                  | (ctl_we[s] & ctl_wd[s][B_TIE] & (clr[s] | empty[s]));
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++)
      if (push[s]) mem[s][wp[s]] <= tx_wd[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        wp[s]  <= '0;
        rp[s]  <= '0;
        cnt[s] <= '0;
      end
      en     <= '0;
      err    <= '0;
      tie    <= '0;
      rie    <= '0;
      irq_tx <= '0;
      irq_rx <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (clr[s]) begin
          wp[s]  <= '0;
          rp[s]  <= '0;
          cnt[s] <= '0;
        end else begin
          if (push[s]) wp[s] <= (wp[s] == PTR_W'(DEPTH - 1)) ? '0 : wp[s] + 1'b1;
          if (pop[s])  rp[s] <= (rp[s] == PTR_W'(DEPTH - 1)) ? '0 : rp[s] + 1'b1;
          cnt[s] <= cnt[s] + CNT_W'(push[s]) - CNT_W'(pop[s]);
        end
        if (ctl_we[s]) begin
          en[s]  <= ctl_wd[s][B_EN];
          tie[s] <= ctl_wd[s][B_TIE];
          rie[s] <= ctl_wd[s][B_RIE];
        end
        err[s] <= (err[s] & ~(ctl_we[s] & ctl_wd[s][B_ERR])) | push_err[s] | rd_err[s];
      end
      irq_tx <= irq_tx_n;
      irq_rx <= irq_rx_n;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= CNT_W'(DEPTH)); // R1
    AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd[g][9:8] == ctl_rd[1-g][1:0]); // R3
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_we[g] && full[g] && !pop[g] && !clr[g]) |=> cnt[g] == CNT_W'(DEPTH)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err[g] && !(ctl_we[g] && ctl_wd[g][B_ERR])) |=> err[g]); // R5
    AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_re[g] && !en[g]) |-> rx_rd[g] == '0); // R2
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] |=> ctl_rd[g][0] && ctl_rd[1-g][8]); // R6
    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop[g] && !push[g] && !clr[g] && cnt[g] == CNT_W'(1)) |=> ctl_rd[1-g][8]); // R8
  end
endmodule

// File: tb/ipc_mailbox_pair_tb_top.sv
module ipc_mailbox_pair_tb_top;
  localparam logic [15:0] EN = 16'h8000, ERR = 16'h4000, RIE = 16'h0400,
                          CLR = 16'h0008, TIE = 16'h0004;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  ctl_we = '0, tx_we = '0, rx_re = '0;
  logic [15:0] ctl_wd [2];
  logic [15:0] ctl_rd [2];
  logic [31:0] tx_wd [2];
  logic [31:0] rx_rd [2];
  logic [1:0]  irq_tx, irq_rx;

  int checks = 0, errors = 0;

  logic [31:0] mbuf [2][16];
  int mhead [2], mcnt [2];
  logic men [2], merr [2], mtie [2], mrie [2];

  ipc_mailbox_pair dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_ctl_we(ctl_we[0]), .a_ctl_wdata(ctl_wd[0]), .a_ctl_rdata(ctl_rd[0]),
    .a_tx_we(tx_we[0]), .a_tx_wdata(tx_wd[0]), .a_rx_re(rx_re[0]), .a_rx_rdata(rx_rd[0]),
    .a_irq_tx_empty(irq_tx[0]), .a_irq_rx_avail(irq_rx[0]),
    .b_ctl_we(ctl_we[1]), .b_ctl_wdata(ctl_wd[1]), .b_ctl_rdata(ctl_rd[1]),
    .b_tx_we(tx_we[1]), .b_tx_wdata(tx_wd[1]), .b_rx_re(rx_re[1]), .b_rx_rdata(rx_rd[1]),
    .b_irq_tx_empty(irq_tx[1]), .b_irq_rx_avail(irq_rx[1])
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stat(input int s);
    return {men[s], merr[s], 3'b000, mrie[s], mcnt[1-s] == 16, mcnt[1-s] == 0,
            5'b00000, mtie[s], mcnt[s] == 16, mcnt[s] == 0};
  endfunction

  function automatic logic [31:0] word(input int s, input int i);
    return 32'h1000_0000 * (s + 1) + 32'h0101_0101 * i;
  endfunction

  task automatic model_ctl(input int s, input logic [15:0] v);
    men[s] = v[15]; mtie[s] = v[2]; mrie[s] = v[10];
    if (v[14]) merr[s] = 1'b0;
    if (v[3]) begin mcnt[s] = 0; mhead[s] = 0; end
  endtask

  task automatic model_push(input int s, input logic [31:0] d);
    if (!men[s]) return;
    if (mcnt[s] == 16) merr[s] = 1'b1;
    else begin
      mbuf[s][(mhead[s] + mcnt[s]) % 16] = d;
      mcnt[s]++;
    end
  endtask

  task automatic model_pop(input int r, output logic [31:0] e);
    e = '0;
    if (!men[r]) return;
    if (mcnt[1-r] == 0) merr[r] = 1'b1;
    else begin
      e = mbuf[1-r][mhead[1-r]];
      mhead[1-r] = (mhead[1-r] + 1) % 16;
      mcnt[1-r]--;
    end
  endtask

  task automatic ctl(input int s, input logic [15:0] v);
    ctl_we[s] = 1'b1; ctl_wd[s] = v;
    @(posedge clk); #1;
    ctl_we[s] = 1'b0;
    model_ctl(s, v);
  endtask

  task automatic push(input int s, input logic [31:0] d);
    tx_we[s] = 1'b1; tx_wd[s] = d;
    @(posedge clk); #1;
    tx_we[s] = 1'b0;
    model_push(s, d);
  endtask

  task automatic pop(input int r, output logic [31:0] a, output logic [31:0] e);
    rx_re[r] = 1'b1;
    #2 a = rx_rd[r];
    @(posedge clk); #1;
    rx_re[r] = 1'b0;
    model_pop(r, e);
  endtask

  task automatic stat_both(input string req);
    chk(req, {16'h0, ctl_rd[0]}, {16'h0, stat(0)});
    chk(req, {16'h0, ctl_rd[1]}, {16'h0, stat(1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, e;
    ctl_wd[0] = '0; ctl_wd[1] = '0; tx_wd[0] = '0; tx_wd[1] = '0;
    for (int s = 0; s < 2; s++) begin
      mhead[s] = 0; mcnt[s] = 0; men[s] = 0; merr[s] = 0; mtie[s] = 0; mrie[s] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 reset a", {16'h0, ctl_rd[0]}, 32'h0101);
    chk("R10 reset b", {16'h0, ctl_rd[1]}, 32'h0101);
    chk("R10 irq idle", {28'h0, irq_tx, irq_rx}, 32'h0);

    ctl(0, EN | RIE | TIE);
    chk("R9 tie on empty a", {31'h0, irq_tx[0]}, 32'h1);
    chk("R9 rie on empty a", {31'h0, irq_rx[0]}, 32'h0);
    ctl(1, EN | RIE | TIE);
    chk("R9 tie on empty b", {31'h0, irq_tx[1]}, 32'h1);
    stat_both("R12 enables readback");

    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 16; i++) begin
        push(s, word(s, i));
        chk("R7 rx irq on push", {31'h0, irq_rx[1-s]}, 32'h1);
        stat_both("R3 status during fill");
      end
      @(posedge clk); #1;
      chk("R7 rx irq single cycle", {31'h0, irq_rx[1-s]}, 32'h0);
      push(s, 32'hDEAD_BEEF);
      chk("R4 overflow no irq", {31'h0, irq_rx[1-s]}, 32'h0);
      stat_both("R4 overflow error");
      ctl(s, EN | RIE | TIE);
      stat_both("R5 write zero keeps error");
      ctl(s, EN | RIE | TIE | ERR);
      stat_both("R5 write one clears error");
      for (int i = 0; i < 16; i++) begin
        pop(1 - s, a, e);
        chk("R1 order", a, word(s, i));
        chk("R8 send-empty irq on drain", {31'h0, irq_tx[s]}, (i == 15) ? 32'h1 : 32'h0);
        stat_both("R3 status during drain");
      end
      pop(1 - s, a, e);
      chk("R4 underflow returns zero", a, 32'h0);
      stat_both("R4 underflow error");
      ctl(1 - s, EN | RIE | TIE | ERR);
      stat_both("R5 clear underflow error");
    end

    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 7; i++) push(0, word(2, r * 7 + i));
      for (int i = 0; i < 7; i++) begin
        pop(1, a, e);
        chk("R1 wrap order", a, word(2, r * 7 + i));
      end
    end
    stat_both("R1 after wrap");

    for (int i = 0; i < 3; i++) push(0, word(3, i));
    tx_we[0] = 1'b1; tx_wd[0] = word(3, 3); rx_re[1] = 1'b1;
    #2 a = rx_rd[1];
    @(posedge clk); #1;
    tx_we[0] = 1'b0; rx_re[1] = 1'b0;
    model_pop(1, e); model_push(0, word(3, 3));
    chk("R11 same-cycle pop data", a, word(3, 0));
    stat_both("R11 count unchanged");
    for (int i = 1; i < 4; i++) begin
      pop(1, a, e);
      chk("R11 order after same-cycle", a, word(3, i));
    end

    push(0, 32'h5555_AAAA);
    ctl(1, EN);
    chk("R9 no rx irq when enable cleared", {31'h0, irq_rx[1]}, 32'h0);
    ctl(1, EN | RIE);
    chk("R9 rx irq on enable with data", {31'h0, irq_rx[1]}, 32'h1);
    ctl(0, EN | TIE | CLR);
    chk("R9 tie with clear fires", {31'h0, irq_tx[0]}, 32'h1);
    stat_both("R6 clear status");
    push(0, 32'h0000_1111);
    ctl_we[0] = 1'b1; ctl_wd[0] = EN | CLR; tx_we[0] = 1'b1; tx_wd[0] = 32'h2222_0000;
    @(posedge clk); #1;
    ctl_we[0] = 1'b0; tx_we[0] = 1'b0;
    model_ctl(0, EN | CLR);
    stat_both("R6 push dropped during clear");

    ctl(0, 16'h0000);
    push(0, 32'h7777_7777);
    stat_both("R2 disabled push ignored");
    push(1, 32'h3333_3333);
    pop(0, a, e);
    chk("R2 disabled read zero", a, 32'h0);
    stat_both("R2 disabled read no change");

    ctl(1, 16'hFFF7);
    stat_both("R12 reserved bits zero");
    pop(1, a, e);
    chk("R4 read empty with all bits set", a, 32'h0);
    stat_both("R12 after read");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule